// File: doc/BRIEF.md
# UART FIFO Interrupt Source Combiner

This block turns the fill state of a UART's receive and transmit queues, the receiver's stale-data flag and activity on the clear-to-send input into a single interrupt request. Eight conditions each have their own detection rule. Each condition is gated by one bit of an 8-bit mask register. The request is the registered OR of every unmasked condition.

The queue conditions follow the occupancy counts with no storage, so they vanish as soon as the count moves. The clear-to-send input is synchronized first. After that, any change of its level sets a sticky change flag, which software clears by writing 1 to it. The synchronized level itself is also available as an output.

Top module: `uart_irq_src`

## Requirements
- R1: After reset the mask register is 0x00, the change flag is 0 and `irq` is 0.
- R2: Source bit 7 follows `old_data`.
- R3: Each change of `cts_raw` in either direction shows on `cts_level` two clocks later, and sets the sticky change flag (source bit 6) one clock after that.
- R4: A write with `wr_sel`=1 and `wr_data[6]`=1 clears the change flag. A write with `wr_data[6]`=0 leaves it unchanged. A new change in the same cycle as a clear keeps the flag set.
- R5: Source bit 5 is 1 exactly when `rx_count` equals `DEPTH`.
- R6: Source bit 4 is 1 exactly when 2·`rx_count` > `DEPTH`.
- R7: Source bit 3 is 1 exactly when `rx_count` ≥ 1.
- R8: Source bit 2 is 1 exactly when `tx_count` is 0.
- R9: Source bit 1 is 1 exactly when 2·`tx_count` < `DEPTH`.
- R10: Source bit 0 is 1 exactly when `tx_count` < `DEPTH`.
- R11: `irq` is 1 in the cycle after any source bit and its mask bit are both 1. It is 0 in the cycle after no such pair exists.
- R12: A write with `wr_sel`=0 loads all eight bits of `wr_data` into the mask register. Bit n of the mask gates source bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = mask register, 1 = write-1-to-clear of the change flag |
| wr_data | input | 8 | Write data |
| rx_count | input | CNT_W | Receive queue occupancy |
| tx_count | input | CNT_W | Transmit queue occupancy |
| old_data | input | 1 | Receiver stale-data flag |
| cts_raw | input | 1 | Asynchronous clear-to-send pin |
| irq | output | 1 | Registered interrupt request |
| src_raw | output | 8 | Unmasked source status, bit 7 down to bit 0 |
| cts_level | output | 1 | Synchronized clear-to-send level |

## Verification
The bench drives the queue counts across the exact half-way and full points.
- An off-by-one comparison would wrongly raise the receive-half source at exactly half full, or the transmit-half source at exactly half empty.
- For the change flag, the bench uses both a rising and a falling edge. A detector that only watches rising edges misses the second one. A flag that is not sticky drops once the level settles. A clear path that ignores the data bit wipes the flag on a write of 0.
- The bench also masks a source that is active and checks that `irq` stays low. It then removes a mask bit and checks that the request falls one cycle later.

// File: rtl/uif_pkg.sv
package uif_pkg;
   typedef logic [7:0] src_vec_t;
   localparam int unsigned SRC_OLD    = 7;
   localparam int unsigned SRC_CTS    = 6;
   localparam int unsigned SRC_RXFULL = 5;
   localparam int unsigned SRC_RXHALF = 4;
   localparam int unsigned SRC_RXRDY  = 3;
   localparam int unsigned SRC_TXEMPT = 2;
   localparam int unsigned SRC_TXHALF = 1;
   localparam int unsigned SRC_TXAVL  = 0;
endpackage

// File: rtl/uif_level_decode.sv
module uif_level_decode #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   output logic [5:0]       lvl_src
);
   localparam int unsigned DW = CNT_W + 1;
   localparam logic [DW-1:0] DEPTH_V = DW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uif_level_decode: DEPTH must be at least 2");
      end
   endgenerate

   logic [DW-1:0] rx_x2, tx_x2, rx_w, tx_w;

   always_comb begin
      rx_w  = {1'b0, rx_count};
      tx_w  = {1'b0, tx_count};
      rx_x2 = {rx_count, 1'b0};
      tx_x2 = {tx_count, 1'b0};
      lvl_src[uif_pkg::SRC_RXFULL] = (rx_w == DEPTH_V);
      lvl_src[uif_pkg::SRC_RXHALF] = (rx_x2 > DEPTH_V);
      lvl_src[uif_pkg::SRC_RXRDY]  = (rx_count != '0);
      lvl_src[uif_pkg::SRC_TXEMPT] = (tx_count == '0);
      lvl_src[uif_pkg::SRC_TXHALF] = (tx_x2 < DEPTH_V);
      lvl_src[uif_pkg::SRC_TXAVL]  = (tx_w < DEPTH_V);
   end
endmodule

// File: rtl/uif_cts_delta.sv
module uif_cts_delta #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic clr,
   output logic level,
   output logic delta
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uif_cts_delta: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev_q;
   logic              delta_q;
   logic              change;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], pin};
   end

   assign level  = chain[STAGES-1];
   assign change = level ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         delta_q <= 1'b0;
      end else begin
         prev_q <= level;
         if (change)   delta_q <= 1'b1;
         else if (clr) delta_q <= 1'b0;
      end
   end

   assign delta = delta_q;

   // R3: a seen change always leaves the flag set
   a_r3_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
      change |=> delta_q);
   // R4: without a clear the flag holds
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (delta_q && !clr) |=> delta_q);
   // R4: the flag only rises on a change
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!delta_q && !change) |=> !delta_q);
endmodule

// File: rtl/uif_irq_combine.sv
module uif_irq_combine (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_wr,
   input  logic [7:0]       mask_wdata,
   input  uif_pkg::src_vec_t src,
   output logic             irq
);
   uif_pkg::src_vec_t mask_q;
   logic              irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(src & mask_q);
   end

   assign irq = irq_q;

   // R11: request rises one cycle after an enabled source
   a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src & mask_q)) |=> irq_q);
   // R11: request falls one cycle after nothing is enabled and active
   a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(src & mask_q)) |=> !irq_q);
   // R12: mask only moves on a mask write
   a_r12_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src #(
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [7:0]       wr_data,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             old_data,
   input  logic             cts_raw,
   output logic             irq,
   output logic [7:0]       src_raw,
   output logic             cts_level
);
   logic [5:0] lvl_src;
   logic       delta;
   logic       delta_clr;
   logic       mask_wr;

   assign mask_wr   = wr_en & ~wr_sel;
   assign delta_clr = wr_en & wr_sel & wr_data[uif_pkg::SRC_CTS];

   uif_level_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lvl (
      .rx_count (rx_count),
      .tx_count (tx_count),
      .lvl_src  (lvl_src)
   );

   uif_cts_delta #(.STAGES(SYNC_STAGES)) u_cts (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cts_raw),
      .clr   (delta_clr),
      .level (cts_level),
      .delta (delta)
   );

   assign src_raw = {old_data, delta, lvl_src};

   uif_irq_combine u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_wr    (mask_wr),
      .mask_wdata (wr_data),
      .src        (src_raw),
      .irq        (irq)
   );

   // R5/R6: a full receive queue is also more than half full
   a_r5_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
      src_raw[uif_pkg::SRC_RXFULL] |-> src_raw[uif_pkg::SRC_RXHALF]);
   // R7: above half implies data present
   a_r7_half_implies_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      src_raw[uif_pkg::SRC_RXHALF] |-> src_raw[uif_pkg::SRC_RXRDY]);
   // R8/R9/R10: empty transmit queue is below half and has room
   a_r8_empty_implies_room: assert property (@(posedge clk) disable iff (!rst_n)
      src_raw[uif_pkg::SRC_TXEMPT] |-> (src_raw[uif_pkg::SRC_TXHALF] && src_raw[uif_pkg::SRC_TXAVL]));
endmodule

// File: tb/uart_irq_src_tb_top.sv
module uart_irq_src_tb_top;
   localparam int unsigned DEPTH = 8;
   localparam int unsigned CNT_W = 4;
   localparam int NV = 7;
   // {rx_count, tx_count, old_data, expected src_raw with bit 6 = 0}
   localparam logic [16:0] VEC [NV] = '{
      {4'd0, 4'd0, 1'b0, 8'b0000_0111},
      {4'd1, 4'd8, 1'b0, 8'b0000_1000},
      {4'd4, 4'd4, 1'b1, 8'b1000_1001},
      {4'd5, 4'd3, 1'b0, 8'b0001_1011},
      {4'd8, 4'd7, 1'b0, 8'b0011_1001},
      {4'd7, 4'd1, 1'b1, 8'b1001_1011},
      {4'd0, 4'd8, 1'b1, 8'b1000_0000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
   logic old_data = 1'b0, cts_raw = 1'b0;
   logic irq, cts_level;
   logic [7:0] src_raw;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   uart_irq_src #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rx_count(rx_count), .tx_count(tx_count), .old_data(old_data), .cts_raw(cts_raw),
      .irq(irq), .src_raw(src_raw), .cts_level(cts_level));

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      tick(1);
      wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      check(irq == 1'b0, "R1 irq", irq, 0);
      check(src_raw[6] == 1'b0, "R1 delta", src_raw[6], 0);
      rst_n = 1'b1;
      tick(2);
      // R1: mask is zero -> active tx sources raise nothing
      check(irq == 1'b0, "R1 mask zero", irq, 0);

      wr(1'b0, 8'hFF);
      for (int v = 0; v < NV; v++) begin
         rx_count = VEC[v][16:13];
         tx_count = VEC[v][12:9];
         old_data = VEC[v][8];
         #1;
         // R2 R5 R6 R7 R8 R9 R10 source decode
         check(src_raw == VEC[v][7:0], "R2/R5-R10 src", src_raw, VEC[v][7:0]);
         tick(1);
         check(irq == (|VEC[v][7:0]), "R11 irq follow", irq, |VEC[v][7:0]);
      end

      // R12: mask only rx-ready; tx-empty present but masked
      rx_count = 0; tx_count = 0; old_data = 0;
      wr(1'b0, 8'h08);
      tick(1);
      check(irq == 1'b0, "R12 masked source", irq, 0);
      rx_count = 1;
      tick(1);
      check(irq == 1'b1, "R12 enabled source", irq, 1);
      wr(1'b0, 8'h00);
      tick(1);
      check(irq == 1'b0, "R11 fall after mask clear", irq, 0);

      // R3: rising edge of cts
      rx_count = 0; tx_count = 4'd8;
      cts_raw = 1'b1;
      tick(1);
      check(cts_level == 1'b0, "R3 level not early", cts_level, 0);
      tick(1);
      check(cts_level == 1'b1, "R3 level after sync", cts_level, 1);
      tick(1);
      check(src_raw[6] == 1'b1, "R3 delta on rise", src_raw[6], 1);
      tick(3);
      check(src_raw[6] == 1'b1, "R4 delta sticky", src_raw[6], 1);
      // R4: write of 0 leaves flag
      wr(1'b1, 8'hBF);
      check(src_raw[6] == 1'b1, "R4 w0 no effect", src_raw[6], 1);
      wr(1'b1, 8'h40);
      check(src_raw[6] == 1'b0, "R4 w1 clears", src_raw[6], 0);

      // R3: falling edge, with interrupt through mask bit 6
      wr(1'b0, 8'h40);
      cts_raw = 1'b0;
      tick(2);
      check(cts_level == 1'b0, "R3 level fall", cts_level, 0);
      tick(1);
      check(src_raw[6] == 1'b1, "R3 delta on fall", src_raw[6], 1);
      tick(1);
      check(irq == 1'b1, "R11 irq from delta", irq, 1);
      wr(1'b1, 8'h40);
      tick(1);
      check(irq == 1'b0, "R11 irq after clear", irq, 0);

      // R4: change arriving in the same cycle as the clear wins
      cts_raw = 1'b1;
      tick(2);
      wr(1'b1, 8'h40);
      check(src_raw[6] == 1'b1, "R4 set beats clear", src_raw[6], 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule